// File: doc/BRIEF.md
# Dual-Clock FIFO with In-Band Threshold Programming

This block is a first-in first-out buffer of 18-bit words. The write port and the read port run on unrelated clocks. Pointers cross between the two domains as Gray code through a configurable chain of synchronizer flops. Five active-low status outputs describe the fill level: empty, almost empty, half full, almost full and full. Empty and almost empty are registered on the read clock. Full, almost full and half full are registered on the write clock.

The almost-empty and almost-full thresholds are held in two 16-bit offset registers. These registers are programmed through the normal data path. While the load-select input is low, write-enabled write-clock edges store the low 16 data bits into the offset registers, alternating between them. Read-enabled read-clock edges return the registers on the read data output in the same alternating order. Raising load-select returns the block to ordinary FIFO traffic, whether or not both registers were written. Offsets should be changed only while the read side is idle, because the read domain uses the empty offset directly.

Top module: `dfifo_pflags`

## Requirements
- R1: A word on `din` is stored on a rising `wclk` edge when `wr_en_n` is 0, `ld_n` is 1 and `full_n` is 1. Words leave the FIFO in the order they were stored. When `ld_n` is 1 and `wr_en_n` is 1, nothing is stored.
- R2: `full_n` is 0 exactly when the write domain's count equals DEPTH. It changes only on rising `wclk` edges. While it is 0, no word is stored, whatever `wr_en_n` does.
- R3: `empty_n` is 0 exactly when the read domain's count is zero. It changes only on rising `rclk` edges. While it is 0, no word is removed and `dout` keeps the last word validly read, even when `rd_en_n` is 0.
- R4: On a rising `rclk` edge with `rd_en_n` = 0, `ld_n` = 1 and `empty_n` = 1, the oldest stored word appears on `dout`, which is a register.
- R5: On a rising `wclk` edge with `ld_n` = 0 and `wr_en_n` = 0, `din[15:0]` goes into an offset register and no FIFO word is stored. The first such edge after reset loads the empty offset, the next loads the full offset, and the two keep alternating. The sequence position is kept across periods when `ld_n` is high.
- R6: On a rising `rclk` edge with `ld_n` = 0 and `rd_en_n` = 0, `dout` becomes {2'b00, offset} and no FIFO word is removed. The order is empty offset first, then full offset, alternating, and this order is independent of the load sequence.
- R7: `ae_n` is 0 when the read-domain count is at or below the empty offset.
- R8: `af_n` is 0 when DEPTH minus the write-domain count is at or below the full offset.
- R9: `hf_n` is 0 when the write-domain count is greater than DEPTH/2.
- R10: While `rst_n` is 0, the following hold: `empty_n` and `ae_n` are 0; `full_n`, `af_n` and `hf_n` are 1; `dout` is 0; both offsets take their parameter defaults; both sequence positions point at the empty offset.
- R11: With SYNC_STAGES = 2, a store or removal is reflected in the other domain's flags on the third rising edge of the other clock that follows it. The domain's own flags reflect it on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous reset for both domains, active low |
| wr_en_n | input | 1 | Write enable, active low |
| rd_en_n | input | 1 | Read enable, active low |
| ld_n | input | 1 | Offset-register select, active low |
| din | input | DATA_W | Write data; low 16 bits carry offset values |
| dout | output | DATA_W | Registered read data or offset readback |
| empty_n | output | 1 | Empty flag, active low, read domain |
| ae_n | output | 1 | Almost-empty flag, active low, read domain |
| hf_n | output | 1 | Half-full flag, active low, write domain |
| af_n | output | 1 | Almost-full flag, active low, write domain |
| full_n | output | 1 | Full flag, active low, write domain |

## Verification
The bench builds the block with DEPTH = 16, an empty-offset default of 2, a full-offset default of 3 and two synchronizer stages. The shallow depth lets overflow attempts, underflow attempts and the half-full boundary occur within a few dozen cycles. The two different defaults make a swapped readback order or a wrong reset value visible at once. Both clocks run at the same rate with a fixed phase offset, so the crossing latency of R11 is exact and every flag can be compared on every edge.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;

   localparam int OFFSET_W = 16;

   typedef enum logic {
      OFS_EMPTY = 1'b0,
      OFS_FULL  = 1'b1
   } ofs_sel_e;

   typedef struct packed {
      logic [OFFSET_W-1:0] ae;
      logic [OFFSET_W-1:0] af;
   } ofs_pair_t;

endpackage

// File: rtl/dfifo_gray_sync.sv
module dfifo_gray_sync #(
   parameter int PW     = 9,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] gray_in,
   output logic [PW-1:0] bin_out
);

   logic [STAGES-1:0][PW-1:0] stg;
   logic [PW-1:0]             g_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], gray_in};
   end

   assign g_sync = stg[STAGES-1];

   for (genvar i = 0; i < PW; i++) begin : g_g2b
      assign bin_out[i] = ^g_sync[PW-1:i];
   end

endmodule

// File: rtl/dfifo_mem.sv
module dfifo_mem #(
   parameter int DATA_W = 18,
   parameter int AW     = 8
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int WORDS = 1 << AW;

   logic [DATA_W-1:0] cells [WORDS];

   always_ff @(posedge wclk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/dfifo_wr_ctl.sv
module dfifo_wr_ctl
   import dfifo_pkg::*;
#(
   parameter int DEPTH   = 256,
   parameter int PW      = 9,
   parameter int AE_INIT = 127,
   parameter int AF_INIT = 127
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en_n,
   input  logic                ld_n,
   input  logic [OFFSET_W-1:0] ofs_in,
   input  logic [PW-1:0]       rbin_sync,
   output logic                we,
   output logic [PW-1:0]       wbin,
   output logic [PW-1:0]       wgray,
   output ofs_pair_t           ofs,
   output ofs_sel_e            wsel,
   output logic                full_n,
   output logic                af_n,
   output logic                hf_n
);

   localparam int CW = ((PW > OFFSET_W) ? PW : OFFSET_W) + 1;
   localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
   localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

   logic          load_op;
   logic [PW-1:0] wbin_nxt;
   logic [PW-1:0] used;
   logic [PW-1:0] free;

   always_comb begin
      load_op  = !ld_n && !wr_en_n;
      we       = ld_n && !wr_en_n && full_n;
      wbin_nxt = wbin + PW'(we);
      used     = wbin_nxt - rbin_sync;
      free     = DEPTH_P - used;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin   <= '0;
         wgray  <= '0;
         full_n <= 1'b1;
         af_n   <= 1'b1;
         hf_n   <= 1'b1;
         ofs.ae <= OFFSET_W'(AE_INIT);
         ofs.af <= OFFSET_W'(AF_INIT);
         wsel   <= OFS_EMPTY;
      end else begin
         wbin   <= wbin_nxt;
         wgray  <= wbin_nxt ^ (wbin_nxt >> 1);
         full_n <= (used != DEPTH_P);
         af_n   <= !(CW'(free) <= CW'(ofs.af));
         hf_n   <= !(used > HALF_P);
         if (load_op) begin
            if (wsel == OFS_EMPTY) ofs.ae <= ofs_in;
            else                   ofs.af <= ofs_in;
            wsel <= (wsel == OFS_EMPTY) ? OFS_FULL : OFS_EMPTY;
         end
      end
   end

endmodule

// File: rtl/dfifo_rd_ctl.sv
module dfifo_rd_ctl
   import dfifo_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int PW     = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en_n,
   input  logic              ld_n,
   input  ofs_pair_t         ofs,
   input  logic [PW-1:0]     wbin_sync,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              re,
   output logic [PW-1:0]     rbin,
   output logic [PW-1:0]     rgray,
   output ofs_sel_e          rsel,
   output logic [DATA_W-1:0] dout,
   output logic              empty_n,
   output logic              ae_n
);

   localparam int CW = ((PW > OFFSET_W) ? PW : OFFSET_W) + 1;

   logic          peek;
   logic [PW-1:0] rbin_nxt;
   logic [PW-1:0] used;

   always_comb begin
      peek     = !ld_n && !rd_en_n;
      re       = ld_n && !rd_en_n && empty_n;
      rbin_nxt = rbin + PW'(re);
      used     = wbin_sync - rbin_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin    <= '0;
         rgray   <= '0;
         rsel    <= OFS_EMPTY;
         dout    <= '0;
         empty_n <= 1'b0;
         ae_n    <= 1'b0;
      end else begin
         rbin    <= rbin_nxt;
         rgray   <= rbin_nxt ^ (rbin_nxt >> 1);
         empty_n <= (used != '0);
         ae_n    <= !(CW'(used) <= CW'(ofs.ae));
         if (peek) begin
            dout <= DATA_W'((rsel == OFS_EMPTY) ? ofs.ae : ofs.af);
            rsel <= (rsel == OFS_EMPTY) ? OFS_FULL : OFS_EMPTY;
         end else if (re) begin
            dout <= mem_rdata;
         end
      end
   end

endmodule

// File: rtl/dfifo_pflags.sv
module dfifo_pflags
   import dfifo_pkg::*;
#(
   parameter int DATA_W      = 18,
   parameter int DEPTH       = 256,
   parameter int AE_INIT     = 127,
   parameter int AF_INIT     = 127,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              rst_n,
   input  logic              wr_en_n,
   input  logic              rd_en_n,
   input  logic              ld_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              empty_n,
   output logic              ae_n,
   output logic              hf_n,
   output logic              af_n,
   output logic              full_n
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if ((DEPTH < 4) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (OFFSET_W > DATA_W) begin : g_bad_width
      $error("DATA_W must hold an offset value");
   end
   if ((AE_INIT < 0) || (AF_INIT < 0) || (AE_INIT >= (1 << OFFSET_W)) ||
       (AF_INIT >= (1 << OFFSET_W))) begin : g_bad_init
      $error("offset defaults must fit the offset width");
   end

   logic              we;
   logic              re;
   logic [PW-1:0]     wbin;
   logic [PW-1:0]     wgray;
   logic [PW-1:0]     rbin;
   logic [PW-1:0]     rgray;
   logic [PW-1:0]     wbin_at_r;
   logic [PW-1:0]     rbin_at_w;
   logic [DATA_W-1:0] mem_rdata;
   ofs_pair_t         ofs;
   ofs_sel_e          wsel;
   ofs_sel_e          rsel;

   dfifo_wr_ctl #(
      .DEPTH   (DEPTH),
      .PW      (PW),
      .AE_INIT (AE_INIT),
      .AF_INIT (AF_INIT)
   ) u_wr (
      .clk       (wclk),
      .rst_n     (rst_n),
      .wr_en_n   (wr_en_n),
      .ld_n      (ld_n),
      .ofs_in    (din[OFFSET_W-1:0]),
      .rbin_sync (rbin_at_w),
      .we        (we),
      .wbin      (wbin),
      .wgray     (wgray),
      .ofs       (ofs),
      .wsel      (wsel),
      .full_n    (full_n),
      .af_n      (af_n),
      .hf_n      (hf_n)
   );

   dfifo_rd_ctl #(
      .DATA_W (DATA_W),
      .PW     (PW)
   ) u_rd (
      .clk       (rclk),
      .rst_n     (rst_n),
      .rd_en_n   (rd_en_n),
      .ld_n      (ld_n),
      .ofs       (ofs),
      .wbin_sync (wbin_at_r),
      .mem_rdata (mem_rdata),
      .re        (re),
      .rbin      (rbin),
      .rgray     (rgray),
      .rsel      (rsel),
      .dout      (dout),
      .empty_n   (empty_n),
      .ae_n      (ae_n)
   );

   dfifo_gray_sync #(
      .PW     (PW),
      .STAGES (SYNC_STAGES)
   ) u_w2r (
      .clk     (rclk),
      .rst_n   (rst_n),
      .gray_in (wgray),
      .bin_out (wbin_at_r)
   );

   dfifo_gray_sync #(
      .PW     (PW),
      .STAGES (SYNC_STAGES)
   ) u_r2w (
      .clk     (wclk),
      .rst_n   (rst_n),
      .gray_in (rgray),
      .bin_out (rbin_at_w)
   );

   dfifo_mem #(
      .DATA_W (DATA_W),
      .AW     (AW)
   ) u_mem (
      .wclk  (wclk),
      .we    (we),
      .waddr (wbin[AW-1:0]),
      .wdata (din),
      .raddr (rbin[AW-1:0]),
      .rdata (mem_rdata)
   );

endmodule

// File: rtl/dfifo_pflags_chk.sv
module dfifo_pflags_chk #(
   parameter int PW     = 9,
   parameter int DATA_W = 18
) (
   input logic              wclk,
   input logic              rclk,
   input logic              rst_n,
   input logic              wr_en_n,
   input logic              rd_en_n,
   input logic              ld_n,
   input logic              full_n,
   input logic              af_n,
   input logic              hf_n,
   input logic              empty_n,
   input logic              ae_n,
   input logic [PW-1:0]     wbin,
   input logic [PW-1:0]     rbin,
   input logic [DATA_W-1:0] dout,
   input logic              wsel,
   input logic              rsel
);

   // R2
   no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      !full_n |=> $stable(wbin));

   // R3
   no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
      (!empty_n && ld_n) |=> ($stable(dout) && $stable(rbin)));

   // R1
   wptr_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      1'b1 |=> ((wbin == $past(wbin)) || (wbin == PW'($past(wbin) + 1'b1))));

   // R7
   empty_is_low_chk: assert property (@(posedge rclk) disable iff (!rst_n)
      !empty_n |-> !ae_n);

   // R8
   full_is_near_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      !full_n |-> !af_n);

   // R9
   full_is_half_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      !full_n |-> !hf_n);

   // R5
   load_toggle_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      (!ld_n && !wr_en_n) |=> ((wsel != $past(wsel)) && $stable(wbin)));

   // R6
   peek_toggle_chk: assert property (@(posedge rclk) disable iff (!rst_n)
      (!ld_n && !rd_en_n) |=> ((rsel != $past(rsel)) && $stable(rbin)));

endmodule

bind dfifo_pflags dfifo_pflags_chk #(
   .PW     (PW),
   .DATA_W (DATA_W)
) u_chk (
   .wclk    (wclk),
   .rclk    (rclk),
   .rst_n   (rst_n),
   .wr_en_n (wr_en_n),
   .rd_en_n (rd_en_n),
   .ld_n    (ld_n),
   .full_n  (full_n),
   .af_n    (af_n),
   .hf_n    (hf_n),
   .empty_n (empty_n),
   .ae_n    (ae_n),
   .wbin    (wbin),
   .rbin    (rbin),
   .dout    (dout),
   .wsel    (wsel),
   .rsel    (rsel)
);

// File: tb/dfifo_pflags_test.sv
`timescale 1ns/1ps
module dfifo_pflags_test;

   localparam int DW    = 18;
   localparam int DEPTH = 16;
   localparam int AE0   = 2;
   localparam int AF0   = 3;

   logic          wclk = 1'b0;
   logic          rclk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en_n = 1'b1;
   logic          rd_en_n = 1'b1;
   logic          ld_n = 1'b1;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          empty_n, ae_n, hf_n, af_n, full_n;

   int checks = 0;
   int bad = 0;
   int wmode = 0;
   int rmode = 0;
   int ld_val = 4;
   bit done = 0;

   // reference model state
   logic [DW-1:0] q[$];
   int  wdone = 0, rdone = 0;
   int  rd_d1 = 0, rd_d2 = 0, wr_d1 = 0, wr_d2 = 0;
   int  m_ae = AE0, m_af = AF0;
   bit  m_wsel = 0, m_rsel = 0;
   bit  m_full_n = 1, m_af_n = 1, m_hf_n = 1;
   bit  m_empty_n = 0, m_ae_n = 0;
   logic [DW-1:0] m_dout = '0;
   string m_dtag = "R10";

   dfifo_pflags #(
      .DATA_W      (DW),
      .DEPTH       (DEPTH),
      .AE_INIT     (AE0),
      .AF_INIT     (AF0),
      .SYNC_STAGES (2)
   ) uut (
      .wclk    (wclk),
      .rclk    (rclk),
      .rst_n   (rst_n),
      .wr_en_n (wr_en_n),
      .rd_en_n (rd_en_n),
      .ld_n    (ld_n),
      .din     (din),
      .dout    (dout),
      .empty_n (empty_n),
      .ae_n    (ae_n),
      .hf_n    (hf_n),
      .af_n    (af_n),
      .full_n  (full_n)
   );

   initial forever #2 wclk = ~wclk;
   initial begin
      #1;
      forever #2 rclk = ~rclk;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // write-domain model
   initial forever begin
      int used, cnt, nv;
      bit doload;
      @(posedge wclk or negedge rst_n);
      if (!rst_n) begin
         wdone = 0; rd_d1 = 0; rd_d2 = 0;
         m_full_n = 1; m_af_n = 1; m_hf_n = 1;
         m_ae = AE0; m_af = AF0; m_wsel = 0;
         q.delete();
      end else begin
         used = rd_d2; rd_d2 = rd_d1; rd_d1 = rdone;
         doload = 0; nv = 0;
         if (!ld_n && !wr_en_n) begin
            doload = 1; nv = int'(din[15:0]);
         end else if (ld_n && !wr_en_n && m_full_n) begin
            q.push_back(din); wdone++;
         end
         cnt = wdone - used;
         m_full_n = (cnt != DEPTH);
         m_af_n = !((DEPTH - cnt) <= m_af);
         m_hf_n = !(cnt > DEPTH / 2);
         if (doload) begin
            if (!m_wsel) m_ae = nv; else m_af = nv;
            m_wsel = ~m_wsel;
         end
      end
   end

   // read-domain model
   initial forever begin
      int usedw, cnt;
      @(posedge rclk or negedge rst_n);
      if (!rst_n) begin
         rdone = 0; wr_d1 = 0; wr_d2 = 0;
         m_empty_n = 0; m_ae_n = 0; m_dout = '0; m_rsel = 0; m_dtag = "R10";
      end else begin
         usedw = wr_d2; wr_d2 = wr_d1; wr_d1 = wdone;
         if (!ld_n && !rd_en_n) begin
            m_dout = DW'(m_rsel ? m_af : m_ae);
            m_rsel = ~m_rsel; m_dtag = "R6";
         end else if (ld_n && !rd_en_n) begin
            if (m_empty_n) begin
               m_dout = q.pop_front(); rdone++; m_dtag = "R1/R4";
            end else m_dtag = "R3";
         end
         cnt = usedw - rdone;
         m_empty_n = (cnt != 0);
         m_ae_n = !(cnt <= m_ae);
      end
   end

   // write side: compare then drive
   initial forever begin
      @(negedge wclk);
      chk("R2/R11 full_n", full_n, m_full_n);
      chk("R8/R5 af_n", af_n, m_af_n);
      chk("R9 hf_n", hf_n, m_hf_n);
      case (wmode)
         1: begin wr_en_n = 1'b0; din = DW'($urandom); end
         2: begin wr_en_n = 1'($urandom % 2); din = DW'($urandom); end
         3: begin wr_en_n = 1'b0; din = {2'b11, 16'(ld_val)}; ld_val += 3; end
         default: wr_en_n = 1'b1;
      endcase
   end

   // read side: compare then drive
   initial forever begin
      @(negedge rclk);
      chk("R3/R11 empty_n", empty_n, m_empty_n);
      chk("R7/R5 ae_n", ae_n, m_ae_n);
      chk($sformatf("%s dout", m_dtag), dout, m_dout);
      case (rmode)
         1: rd_en_n = 1'b0;
         2: rd_en_n = 1'($urandom % 2);
         default: rd_en_n = 1'b1;
      endcase
   end

   task automatic step(input int n);
      repeat (n) @(posedge wclk);
      #0.5;
   endtask

   initial begin
      step(5);
      rst_n = 1'b1;
      step(1);
      // R10: reset state at the ports
      chk("R10 empty_n", empty_n, 1'b0);
      chk("R10 full_n", full_n, 1'b1);
      chk("R10 dout", dout, '0);
      // R1 R2: fill past full
      wmode = 1; step(24); wmode = 0; step(6);
      chk("R2 full reached", full_n, 1'b0);
      // R3 R4: drain past empty
      rmode = 1; step(24); rmode = 0; step(6);
      chk("R3 empty reached", empty_n, 1'b0);
      // R6 R10: readback of defaults
      ld_n = 1'b0; rmode = 1; step(3); rmode = 0;
      // R5: three loads, then readback four
      wmode = 3; step(3); wmode = 0; step(2);
      rmode = 1; step(4); rmode = 0;
      // partial load of one register, back to traffic
      wmode = 3; step(1); wmode = 0; step(1);
      ld_n = 1'b1; step(2);
      // mixed traffic
      wmode = 2; rmode = 2; step(600);
      wmode = 1; rmode = 2; step(200);
      wmode = 2; rmode = 1; step(200);
      wmode = 2; rmode = 2; step(100);
      // R10: reset in mid-traffic, defaults restored
      rst_n = 1'b0; step(3);
      wmode = 0; rmode = 0; step(1);
      rst_n = 1'b1; step(2);
      ld_n = 1'b0; rmode = 1; step(2); rmode = 0; step(1);
      ld_n = 1'b1;
      wmode = 2; rmode = 2; step(300);
      wmode = 0; rmode = 1; step(40);
      rmode = 0; step(4);
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge wclk);
      if (!done) begin
         checks++; bad++;
         $display("FAIL watchdog timeout (all requirements) act=running exp=finished");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

endmodule